// File: doc/BRIEF.md
# Clear-on-read minimum extremes detector

This block watches the stream of signed 24-bit conversion results from a multi-channel sigma-delta filter path. It keeps the lowest result it has seen and the 3-bit index of the channel that produced it. Software reads both through a single 32-bit word. A read returns the current contents and re-arms the detector, so the next interval starts from a clean state.

Results arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is high in every cycle, including during reset, so a result is accepted in any cycle where `in_valid` is high. The read strobe `rd_en` is a plain control input. While it is high, `rd_data` shows the contents held before the read. The re-armed state shows on the next cycle.

If a result arrives in the same cycle as a read, it is not lost. It is compared against the re-armed value rather than against the old minimum.

Top module: `min_extreme_tracker`

## Requirements
- R1: After reset `rd_data` is 0x00000000, which means a stored minimum of 0 and a channel of 0.
- R2: `rd_data` holds the minimum in bits 31:8 and the channel in bits 2:0. Bits 7:3 always read as zero.
- R3: A result that is accepted and is strictly smaller than the stored minimum, compared as signed two's complement, replaces it. Its channel is recorded with it, and both show on `rd_data` from the next cycle.
- R4: A result that is equal to or larger than the stored minimum leaves the minimum and the channel unchanged.
- R5: In a cycle with `in_valid` low, the stored contents do not change, whatever `in_data` and `in_chan` carry.
- R6: A read with no accepted result in that cycle makes `rd_data` equal to 0x7FFFFF00 from the next cycle, which means a minimum of 0x7FFFFF and a channel of 0.
- R7: During a cycle with `rd_en` high, `rd_data` shows the contents held before the read.
- R8: When a read and an accepted result fall in the same cycle, the result is compared against 0x7FFFFF. It is stored with its channel when it is smaller; otherwise the word becomes 0x7FFFFF00.
- R9: `in_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion result is present |
| in_ready | output | 1 | Always high; the block never stalls the stream |
| in_data | input | 24 | Signed conversion result |
| in_chan | input | 3 | Channel that produced the result |
| rd_en | input | 1 | Read strobe: return the word now and re-arm |
| rd_data | output | 32 | Read word: minimum in bits 31:8, channel in bits 2:0 |

## Verification
The assertions check several rules on every cycle:
- the stored minimum never rises between reads;
- the stored contents hold while no result and no read arrive;
- a lone read always lands on the re-armed word;
- a strictly smaller result is always captured together with its channel;
- the reserved bits stay zero and `in_ready` stays high.

Only the bench's scenarios can show the following:
- the exact reset word of zero;
- that a read shows the old contents in its own cycle;
- the outcome of a read and a result colliding in one cycle, including a colliding result equal to 0x7FFFFF;
- the handling of equal values and of the most negative input.

// File: rtl/minx_pkg.sv
package minx_pkg;
  localparam int DATA_W = 24;
  localparam int CH_W   = 3;
  localparam int WORD_W = 32;

  function automatic logic [DATA_W-1:0] max_pos();
    return {1'b0, {(DATA_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/minx_less.sv
module minx_less #(
  parameter int W = 24
) (
  input  logic [W-1:0] cand,
  input  logic [W-1:0] ref_val,
  output logic         lt
);
  // Signed strict less-than. Flipping the sign bits turns this into an unsigned compare.
  logic [W-1:0] cand_b, ref_b;
  always_comb begin
    cand_b = {~cand[W-1], cand[W-2:0]};
    ref_b  = {~ref_val[W-1], ref_val[W-2:0]};
    lt     = cand_b < ref_b;
  end
endmodule

// File: rtl/minx_state.sv
module minx_state #(
  parameter int DATA_W = 24,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [DATA_W-1:0] res,
  input  logic [CH_W-1:0]   res_ch,
  input  logic              rd,
  input  logic              lt,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] min_q,
  output logic [CH_W-1:0]   ch_q
);
  localparam logic [DATA_W-1:0] ARM_VAL = {1'b0, {(DATA_W-1){1'b1}}};

  logic [CH_W-1:0] base_ch;
  logic            take;

  always_comb begin
    base    = rd ? ARM_VAL : min_q;
    base_ch = rd ? '0 : ch_q;
    take    = acc && lt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      min_q <= '0;
      ch_q  <= '0;
    end else begin
      min_q <= take ? res : base;
      ch_q  <= take ? res_ch : base_ch;
    end
  end

  // R5: with no result and no read, the stored contents hold.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !rd) |=> ($stable(min_q) && $stable(ch_q)));

  // R6: a lone read lands on the re-armed value.
  p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !acc) |=> (min_q == ARM_VAL && ch_q == '0));

  // R3: a strictly smaller result is captured together with its channel.
  p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rd && ($signed(res) < $signed(min_q)))
      |=> (min_q == $past(res) && ch_q == $past(res_ch)));

  // R4: without a read, the minimum never rises.
  p_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ($signed(min_q) <= $signed($past(min_q))));
endmodule

// File: rtl/minx_pack.sv
module minx_pack #(
  parameter int DATA_W = 24,
  parameter int CH_W   = 3,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] min_val,
  input  logic [CH_W-1:0]   ch_val,
  output logic [WORD_W-1:0] word
);
  localparam int RSV_W = WORD_W - DATA_W - CH_W;

  generate
    if (RSV_W > 0) begin : g_gap
      assign word = {min_val, {RSV_W{1'b0}}, ch_val};
    end else begin : g_tight
      assign word = {min_val, ch_val};
    end
  endgenerate

  // R2: the gap between the channel field and the minimum field reads as zero.
  always_comb begin
    if (RSV_W > 0) begin
      p_reserved_zero_r2: assert ((word >> CH_W) == WORD_W'(min_val) << RSV_W);
    end
  end
endmodule

// File: rtl/min_extreme_tracker.sv
module min_extreme_tracker
  import minx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CH_W,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_chan,
  input  logic          rd_en,
  output logic [WW-1:0] rd_data
);
  logic          acc, lt;
  logic [DW-1:0] base, min_q;
  logic [CW-1:0] ch_q;

  assign in_ready = 1'b1;
  assign acc      = in_valid && in_ready;

  minx_less #(.W(DW)) u_cmp (
    .cand(in_data), .ref_val(base), .lt(lt)
  );

  minx_state #(.DATA_W(DW), .CH_W(CW)) u_state (
    .clk(clk), .rst_n(rst_n), .acc(acc), .res(in_data), .res_ch(in_chan),
    .rd(rd_en), .lt(lt), .base(base), .min_q(min_q), .ch_q(ch_q)
  );

  minx_pack #(.DATA_W(DW), .CH_W(CW), .WORD_W(WW)) u_pack (
    .min_val(min_q), .ch_val(ch_q), .word(rd_data)
  );

  // R9: the stream is never stalled.
  p_ready_r9: assert property (@(posedge clk) in_ready);
endmodule

// File: tb/tb_min_extreme_tracker.sv
module tb_min_extreme_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 5000;
  localparam int NV         = 11;

  logic        clk = 1'b0;
  logic        rst_n, in_valid, rd_en;
  logic        in_ready;
  logic [23:0] in_data;
  logic [2:0]  in_chan;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  min_extreme_tracker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .rd_en(rd_en), .rd_data(rd_data)
  );

  // Each entry is {rd, valid, chan, data, word expected after the edge}.
  localparam logic [60:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd1, 24'h000005, 32'h00000000},  // R4: larger than the reset value 0
    {1'b0, 1'b1, 3'd2, 24'hFFFFFD, 32'hFFFFFD02},  // R3: -3 is smaller
    {1'b0, 1'b1, 3'd3, 24'hFFFFFD, 32'hFFFFFD02},  // R4: equal value
    {1'b0, 1'b0, 3'd5, 24'hFFFF9C, 32'hFFFFFD02},  // R5: valid low
    {1'b0, 1'b1, 3'd4, 24'h800000, 32'h80000004},  // R3: most negative value
    {1'b1, 1'b0, 3'd0, 24'h000000, 32'h7FFFFF00},  // R6: lone read
    {1'b0, 1'b1, 3'd6, 24'h7FFFFF, 32'h7FFFFF00},  // R4: equal to the armed value
    {1'b0, 1'b1, 3'd7, 24'h000010, 32'h00001007},  // R3
    {1'b1, 1'b1, 3'd5, 24'h000020, 32'h00002005},  // R8: read with a smaller result
    {1'b1, 1'b1, 3'd1, 24'h7FFFFF, 32'h7FFFFF00},  // R8: read with a result equal to the armed value
    {1'b0, 1'b1, 3'd3, 24'h7FFFFE, 32'h7FFFFE03}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  initial begin
    logic [31:0] prev;
    rst_n = 1'b0; in_valid = 1'b0; rd_en = 1'b0; in_data = '0; in_chan = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset word", rd_data, 32'h0);
    check("R9 ready", {31'b0, in_ready}, 32'h1);
    prev = 32'h0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rd_en, in_valid, in_chan, in_data} = VEC[i][60:32];
      #(CLK_PERIOD/4);
      if (rd_en) check("R7 read shows old word", rd_data, prev);
      @(posedge clk);
      #(CLK_PERIOD/4);
      check($sformatf("R3/R4/R5/R6/R8 vector %0d", i), rd_data, VEC[i][31:0]);
      check("R2 reserved bits", {27'b0, rd_data[7:3]}, 32'h0);
      check("R9 ready", {31'b0, in_ready}, 32'h1);
      prev = VEC[i][31:0];
    end

    // R5: garbage on the data pins with valid low over several cycles.
    @(negedge clk); rd_en = 1'b0; in_valid = 1'b0; in_data = 24'h800000; in_chan = 3'd7;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R5 hold over idle cycles", rd_data, 32'h7FFFFE03);

    // R6 and R7: two reads in a row.
    @(negedge clk); rd_en = 1'b1;
    #(CLK_PERIOD/4);
    check("R7 first read", rd_data, 32'h7FFFFE03);
    @(negedge clk);
    check("R7 second read shows re-armed", rd_data, 32'h7FFFFF00);
    @(negedge clk); rd_en = 1'b0;
    check("R6 after double read", rd_data, 32'h7FFFFF00);

    // R1: a reset in mid-run clears the word back to zero.
    @(negedge clk); in_valid = 1'b1; in_data = 24'hFFF000; in_chan = 3'd6;
    @(negedge clk); in_valid = 1'b0;
    check("R3 capture before reset", rd_data, 32'hFFF00006);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset in mid-run", rd_data, 32'h0);
    check("R9 ready after reset", {31'b0, in_ready}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule